// File: doc/BRIEF.md
# Output Arbiter Fault Monitor

This block sits next to one output arbiter of a crossbar switching plane and checks its decisions while the switch carries traffic. Once per cell slot, on a one-cycle slot strobe, it takes the request vector the input ports present to that output and the grant vector the arbiter answers with. It looks for three symptoms of a single arbiter fault: more than one input granted at once, no input granted although some input requests, and one port (or the same group of ports) granted in every slot while another requesting port is never served.

Each symptom has its own flag, registered on the strobe and held until the next strobe, so the flags describe the most recent slot. Each symptom also has a saturating event counter. A fault-tolerance manager reads the counters through a small select-and-read port and can clear any one of them. The stuck check needs a programmable run length: a grant must repeat for that many qualifying slots before it counts as stuck. Only single faults are assumed, so the three checks are independent and may fire together without being told apart.

Top module: `arb_fault_monitor`

## Requirements
- R1: On a slot strobe whose grant vector has two or more bits set, `err_multi` is 1 from the next clock edge on; with zero or one grant bit it is 0.
- R2: On a slot strobe with a nonzero request vector and an all-zero grant vector, `err_loss` is 1 from the next clock edge on; otherwise it is 0.
- R3: A slot with all-zero request and all-zero grant vectors raises none of the three flags.
- R4: A slot qualifies for the stuck check when its grant is nonzero and some request bit lies outside the grant. The run length counts consecutive qualifying slots with an identical grant; `err_stuck` is 1 for a slot whose run length reaches `stuck_len` (a `stuck_len` of 0 or 1 flags the first qualifying slot), and it stays 1 for each further slot of the same run.
- R5: The run restarts at 1 on a qualifying slot whose grant differs from the grant of the previous slot, and drops to 0 on any non-qualifying slot.
- R6: While `slot_stb` is 0, changes on `req_vec`, `gnt_vec` and `stuck_len` do not alter the three flags or the counters.
- R7: On each slot strobe, each counter whose symptom is present in that slot increments by one; a counter at 65535 stays there.
- R8: `rd_data` shows, in the same cycle, the counter picked by `rd_sel`: 0 for grant-multiplicity, 1 for grant-loss, 2 for grant-stuck; `rd_sel` of 3 reads 0.
- R9: `clr_en` with `clr_sel` (same encoding as `rd_sel`) sets the chosen counter to 0 at the next edge; if that counter's symptom is counted in the same cycle, it becomes 1 instead, so the event is kept.
- R10: After reset, all flags, all counters and the stuck run length are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_stb | input | 1 | One-cycle strobe marking the slot's arbitration result |
| req_vec | input | N_PORTS | Requests from the input ports to this output |
| gnt_vec | input | N_PORTS | Grants issued by the arbiter for this output |
| stuck_len | input | RUN_W | Run length at which a repeated grant counts as stuck |
| rd_sel | input | 2 | Counter selected for reading |
| clr_en | input | 1 | Clear request for one counter |
| clr_sel | input | 2 | Counter selected for clearing |
| err_multi | output | 1 | Grant-multiplicity flag of the last slot |
| err_loss | output | 1 | Grant-loss flag of the last slot |
| err_stuck | output | 1 | Grant-stuck flag of the last slot |
| rd_data | output | CNT_W | Value of the selected counter |

## Verification
A counter clear and an increment of that same counter can fall in one clock cycle, and so can the grant-multiplicity and grant-stuck checks on one slot, since a multi-bit grant repeated while another port waits is a stuck group. The bench provokes the first with a directed slot that shows grant loss while `clr_en` targets the loss counter, and expects a count of 1, not 0 or the old value plus one. It provokes the second with a repeated two-bit grant and a third requester, and expects both flags and both counters to move. Random slots also hit these overlaps, and every slot is compared with a bench model built from the requirements.

// File: rtl/arb_mon_pkg.sv
// Package: shared encodings for the output arbiter fault monitor.
// Assumes the three symptom kinds are addressed with a 2-bit selector.
package arb_mon_pkg;

    // Selector encoding shared by the read and clear ports
    typedef enum logic [1:0] {
        KIND_MULTI = 2'd0,
        KIND_LOSS  = 2'd1,
        KIND_STUCK = 2'd2,
        KIND_NONE  = 2'd3
    } err_kind_e;

    localparam int NUM_KINDS = 3;

    // One bit per symptom, indexed by the kind encoding
    typedef struct packed {
        logic stuck;
        logic loss;
        logic multi;
    } err_vec_t;

endpackage

// File: rtl/grant_checker.sv
// Module: grant_checker
// Combinational checks of one arbitration result: more than one grant,
// and no grant while at least one request is pending.
// Assumes req and gnt belong to the same output and the same slot.
module grant_checker #(
    parameter int N_PORTS = 8
) (
    input  logic [N_PORTS-1:0] req,
    input  logic [N_PORTS-1:0] gnt,
    output logic               multi_hit,
    output logic               loss_hit
);

    logic seen_one;
    logic seen_two;

    // Detect two or more grant bits with a one/two-seen scan
    always_comb begin
        seen_one = 1'b0;
        seen_two = 1'b0;
        for (int i = 0; i < N_PORTS; i++) begin
            if (gnt[i]) begin
                seen_two = seen_two | seen_one;
                seen_one = 1'b1;
            end
        end
    end

    // Combine the scan and the request summary into the two symptoms
    always_comb begin
        multi_hit = seen_two;
        loss_hit  = (|req) && !seen_one;
    end

    // R1 R2: a slot cannot both lack a grant and carry several
    always_comb begin
        multi_loss_excl_chk: assert (!(multi_hit && loss_hit));
    end

endmodule

// File: rtl/stuck_tracker.sv
// Module: stuck_tracker
// Counts consecutive qualifying slots that repeat the same grant vector
// while some other port keeps requesting, and reports when the count
// reaches the programmed run length.
// Assumes stb is a single-cycle strobe; state only moves on it.
module stuck_tracker #(
    parameter int N_PORTS = 8,
    parameter int RUN_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stb,
    input  logic [N_PORTS-1:0] req,
    input  logic [N_PORTS-1:0] gnt,
    input  logic [RUN_W-1:0]   run_limit,
    output logic               stuck_hit
);

    localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};
    localparam logic [RUN_W-1:0] RUN_ONE = {{(RUN_W-1){1'b0}}, 1'b1};

    logic [N_PORTS-1:0] prev_gnt_q;
    logic [RUN_W-1:0]   run_q;
    logic [RUN_W-1:0]   run_inc;
    logic [RUN_W-1:0]   run_next;
    logic               qualify;
    logic               same_gnt;

    // Decide whether this slot extends, restarts or breaks the run
    always_comb begin
        qualify  = (|gnt) && (|(req & ~gnt));
        same_gnt = (gnt == prev_gnt_q);
        run_inc  = (run_q == RUN_MAX) ? run_q : run_q + RUN_ONE;
        if (!qualify) begin
            run_next = '0;
        end else if (same_gnt) begin
            run_next = run_inc;
        end else begin
            run_next = RUN_ONE;
        end
        stuck_hit = (run_next != '0) && (run_next >= run_limit);
    end

    // Keep the last grant and the run length, updated once per slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_gnt_q <= '0;
            run_q      <= '0;
        end else if (stb) begin
            prev_gnt_q <= gnt;
            run_q      <= run_next;
        end
    end

    // R5: a live run always belongs to a nonzero grant
    run_has_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q != '0) |-> (prev_gnt_q != '0));

    // R5: a slot with no other requester leaves no run behind
    run_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && ((req & ~gnt) == '0)) |=> (run_q == '0));

endmodule

// File: rtl/event_counter.sv
// Module: event_counter
// Saturating event counter with a synchronous clear; a clear that meets
// an increment in the same cycle leaves a count of one.
// Assumes inc and clr are single-cycle qualifiers.
module event_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // Count events, saturate at the top, clear on request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= inc ? CNT_ONE : '0;
        end else if (inc && (cnt != CNT_MAX)) begin
            cnt <= cnt + CNT_ONE;
        end
    end

    // R7
    cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt == CNT_MAX) && !clr) |=> (cnt == CNT_MAX));

    // R7
    cnt_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt >= $past(cnt)));

    // R9
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt <= CNT_ONE));

endmodule

// File: rtl/arb_fault_monitor.sv
// Module: arb_fault_monitor (top)
// Concurrent monitor for one output arbiter of a crossbar plane. On each
// slot strobe it registers three symptom flags (multiple grants, lost
// grant, stuck grant) and counts each symptom in a saturating counter
// that a manager reads and clears through a select port.
// Assumes single faults; the symptoms are reported independently.
module arb_fault_monitor
    import arb_mon_pkg::*;
#(
    parameter int N_PORTS = 8,
    parameter int RUN_W   = 8,
    parameter int CNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               slot_stb,
    input  logic [N_PORTS-1:0] req_vec,
    input  logic [N_PORTS-1:0] gnt_vec,
    input  logic [RUN_W-1:0]   stuck_len,
    input  logic [1:0]         rd_sel,
    input  logic               clr_en,
    input  logic [1:0]         clr_sel,
    output logic               err_multi,
    output logic               err_loss,
    output logic               err_stuck,
    output logic [CNT_W-1:0]   rd_data
);

    err_vec_t         hit_now;
    err_vec_t         flags_q;
    logic [NUM_KINDS-1:0] hit_bits;
    logic [CNT_W-1:0] cnt_val [NUM_KINDS];

    grant_checker #(
        .N_PORTS (N_PORTS)
    ) u_grant_checker (
        .req       (req_vec),
        .gnt       (gnt_vec),
        .multi_hit (hit_now.multi),
        .loss_hit  (hit_now.loss)
    );

    stuck_tracker #(
        .N_PORTS (N_PORTS),
        .RUN_W   (RUN_W)
    ) u_stuck_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (slot_stb),
        .req       (req_vec),
        .gnt       (gnt_vec),
        .run_limit (stuck_len),
        .stuck_hit (hit_now.stuck)
    );

    // Flatten the symptom struct for indexed counter hookup
    always_comb begin
        hit_bits = hit_now;
    end

    // One counter per symptom kind, incremented on strobed symptoms
    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_cnt
        event_counter #(
            .CNT_W (CNT_W)
        ) u_event_counter (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (slot_stb && hit_bits[k]),
            .clr   (clr_en && (clr_sel == 2'(k))),
            .cnt   (cnt_val[k])
        );
    end

    // Hold the flags of the last slot until the next strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (slot_stb) begin
            flags_q <= hit_now;
        end
    end

    // Drive the flag outputs from the held slot result
    always_comb begin
        err_multi = flags_q.multi;
        err_loss  = flags_q.loss;
        err_stuck = flags_q.stuck;
    end

    // Read mux over the counters; the unused code reads zero
    always_comb begin
        unique case (err_kind_e'(rd_sel))
            KIND_MULTI: rd_data = cnt_val[0];
            KIND_LOSS:  rd_data = cnt_val[1];
            KIND_STUCK: rd_data = cnt_val[2];
            default:    rd_data = '0;
        endcase
    end

    // R6
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_stb |=> ($stable(err_multi) && $stable(err_loss) && $stable(err_stuck)));

    // R1
    multi_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb && ($countones(gnt_vec) >= 2)) |=> err_multi);

    // R3
    idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb && (req_vec == '0) && (gnt_vec == '0)) |=> (!err_multi && !err_loss && !err_stuck));

    // R2
    lost_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb && (req_vec != '0) && (gnt_vec == '0)) |=> err_loss);

endmodule

// File: tb/arb_fault_monitor_bench.sv
// Bench for arb_fault_monitor: directed corner cases plus seeded random
// slots, checked against a model written from the requirements.
module arb_fault_monitor_bench;

    localparam int N  = 8;
    localparam int RW = 8;
    localparam int CW = 16;
    localparam int CMAX = 65535;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          slot_stb = 1'b0;
    logic [N-1:0]  req_vec = '0;
    logic [N-1:0]  gnt_vec = '0;
    logic [RW-1:0] stuck_len = 8'd8;
    logic [1:0]    rd_sel = 2'd0;
    logic          clr_en = 1'b0;
    logic [1:0]    clr_sel = 2'd0;
    logic          err_multi, err_loss, err_stuck;
    logic [CW-1:0] rd_data;

    int checks = 0;
    int failures = 0;

    // Model state
    logic [N-1:0] m_prev = '0;
    int           m_run = 0;
    int           m_cnt [3] = '{0, 0, 0};
    logic [2:0]   m_flags = '0;

    always #10 clk = ~clk;

    arb_fault_monitor #(.N_PORTS(N), .RUN_W(RW), .CNT_W(CW)) u_arb_fault_monitor (
        .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .req_vec(req_vec),
        .gnt_vec(gnt_vec), .stuck_len(stuck_len), .rd_sel(rd_sel),
        .clr_en(clr_en), .clr_sel(clr_sel), .err_multi(err_multi),
        .err_loss(err_loss), .err_stuck(err_stuck), .rd_data(rd_data)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ones(input logic [N-1:0] v);
        int c = 0;
        for (int i = 0; i < N; i++) c += int'(v[i]);
        return c;
    endfunction

    // Model one strobed slot; returns {stuck, loss, multi}
    function automatic logic [2:0] model_slot(input logic [N-1:0] r, input logic [N-1:0] g,
                                              input int k);
        logic mu, lo, st, q;
        int nrun;
        mu = ones(g) >= 2;
        lo = (r != '0) && (g == '0);
        q  = (g != '0) && ((r & ~g) != '0);
        if (!q) nrun = 0;
        else if (g == m_prev) nrun = (m_run >= 255) ? 255 : m_run + 1;
        else nrun = 1;
        st = (nrun != 0) && (nrun >= k);
        m_prev = g;
        m_run = nrun;
        return {st, lo, mu};
    endfunction

    // One strobed slot, entered and left at a falling edge
    task automatic do_slot(input logic [N-1:0] r, input logic [N-1:0] g,
                           input logic clr, input logic [1:0] csel, input bit chk);
        logic [2:0] f;
        req_vec = r; gnt_vec = g; slot_stb = 1'b1;
        clr_en = clr; clr_sel = csel;
        f = model_slot(r, g, int'(stuck_len));
        for (int k = 0; k < 3; k++) begin
            if (clr && csel == 2'(k)) m_cnt[k] = f[k] ? 1 : 0;
            else if (f[k] && m_cnt[k] < CMAX) m_cnt[k]++;
        end
        m_flags = f;
        @(posedge clk);
        @(negedge clk);
        slot_stb = 1'b0; clr_en = 1'b0;
        if (chk) begin
            check("R1 err_multi", int'(err_multi), int'(f[0]));
            check("R2 err_loss", int'(err_loss), int'(f[1]));
            check("R4 err_stuck", int'(err_stuck), int'(f[2]));
        end
    endtask

    task automatic check_cnt(input string tag, input int k);
        rd_sel = 2'(k);
        #1;
        check(tag, int'(rd_data), m_cnt[k]);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            req_vec = N'($urandom); gnt_vec = N'($urandom); stuck_len = RW'($urandom);
            @(negedge clk);
        end
        req_vec = '0; gnt_vec = '0;
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [N-1:0] r, g;
        void'($urandom(32'd4417));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 err_multi", int'(err_multi), 0);
        check("R10 err_loss", int'(err_loss), 0);
        check("R10 err_stuck", int'(err_stuck), 0);
        for (int k = 0; k < 3; k++) check_cnt("R10 counter", k);

        // R1 multiple grants, R2 lost grant, R3 idle slot
        stuck_len = 8'd4;
        do_slot(8'b0000_0110, 8'b0000_0110, 0, 0, 1);
        do_slot(8'b0001_0000, 8'b0000_0000, 0, 0, 1);
        do_slot(8'b0000_0000, 8'b0000_0000, 0, 0, 1);
        check("R3 no flags", int'({err_stuck, err_loss, err_multi}), 0);

        // R4 stuck after four identical grants with a second requester
        for (int i = 0; i < 5; i++) begin
            do_slot(8'b0000_0011, 8'b0000_0001, 0, 0, 1);
            check("R4 stuck run", int'(err_stuck), (i >= 3) ? 1 : 0);
        end
        // R5 grant change restarts the run
        do_slot(8'b0000_0011, 8'b0000_0010, 0, 0, 1);
        check("R5 restart", int'(err_stuck), 0);
        // R5 no other requester breaks the run
        do_slot(8'b0000_0010, 8'b0000_0010, 0, 0, 1);
        check("R5 break", int'(err_stuck), 0);
        stuck_len = 8'd1;
        do_slot(8'b0000_0011, 8'b0000_0010, 0, 0, 1);
        check("R4 len one", int'(err_stuck), 1);
        stuck_len = 8'd0;
        do_slot(8'b0000_0101, 8'b0000_0100, 0, 0, 1);
        check("R4 len zero", int'(err_stuck), 1);

        // Multi and stuck in the same slot: repeated two-bit grant
        stuck_len = 8'd2;
        do_slot(8'b0000_0111, 8'b0000_0011, 0, 0, 1);
        do_slot(8'b0000_0111, 8'b0000_0011, 0, 0, 1);
        check("R1 multi with stuck", int'(err_multi), 1);
        check("R4 stuck with multi", int'(err_stuck), 1);
        for (int k = 0; k < 3; k++) check_cnt("R7 counter", k);

        // R6 inputs ignored without a strobe
        idle(6);
        check("R6 err_multi held", int'(err_multi), int'(m_flags[0]));
        check("R6 err_stuck held", int'(err_stuck), int'(m_flags[2]));
        for (int k = 0; k < 3; k++) check_cnt("R6 counter held", k);

        // R8 unused selector reads zero
        rd_sel = 2'd3; #1;
        check("R8 sel3", int'(rd_data), 0);

        // R9 plain clear, then clear meeting an increment
        stuck_len = 8'd4;
        clr_en = 1'b1; clr_sel = 2'd0;
        @(negedge clk);
        clr_en = 1'b0; m_cnt[0] = 0;
        check_cnt("R9 clear", 0);
        do_slot(8'b0000_1000, 8'b0000_0000, 1, 2'd1, 1);
        check_cnt("R9 clear with event", 1);

        // Random slots
        for (int i = 0; i < 3000; i++) begin
            if (i % 500 == 0) stuck_len = RW'($urandom_range(0, 6));
            r = N'($urandom);
            if ($urandom_range(0, 3) == 0) r = r & N'($urandom);
            case ($urandom_range(0, 7))
                0: g = '0;
                1: g = N'(1) << $urandom_range(0, N-1) | N'(1) << $urandom_range(0, N-1);
                2, 3, 4: g = m_prev;
                default: g = N'(1) << $urandom_range(0, N-1);
            endcase
            do_slot(r, g, ($urandom_range(0, 40) == 0), 2'($urandom_range(0, 2)), 1);
            if (i % 100 == 0) for (int k = 0; k < 3; k++) check_cnt("R7 random counter", k);
        end

        // R7 saturation of the loss counter
        for (int i = 0; i < CMAX + 3; i++) do_slot(8'b1000_0000, 8'b0, 0, 0, 0);
        check_cnt("R7 saturate", 1);
        check("R7 saturate value", int'(rd_data), CMAX);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule